// File: doc/BRIEF.md
# Serial Converter Register Access Engine

This block is a serial-peripheral master that carries out a single register access with a serial delta-sigma converter. A host pulses a start strobe and supplies a command byte, a read/write select, a command-only flag and a 24-bit write word. The engine then produces the chip-select, serial clock and data-out waveforms. On a read it collects the returned word, and when the frame has finished it signals completion with a single-cycle pulse.

A full frame is the command byte followed by a 24-bit payload, 32 serial clocks in all. A write shifts the host's word out. A read drives zeros on the data-out line while the converter's reply is clocked in. A command-only frame stops after the eight command bits, which is how a conversion is triggered. The serial clock rate comes from two parameters, the system clock frequency and the maximum serial clock frequency. Chip select either frames every transaction or, for three-wire boards, stays low permanently.

Top module: `adc_reg_xact`

## Requirements
- R1: After reset, and whenever no transaction is running, `sclk` is 0, `mosi` is 0 and `busy` is 0. In the per-transaction chip-select mode `cs_n` is also 1.
- R2: When `req_start` is seen while `busy` is 0, `busy` is 1 from the next clock. A `req_start` seen while `busy` is 1 does not change the running frame and does not queue a further transaction.
- R3: A write (`req_rd`=0, `req_cmd_only`=0) gives exactly 32 rising `sclk` edges. The first 8 `mosi` bits are `req_cmd` and the next 24 are `req_wdata`, most significant bit first throughout.
- R4: A read (`req_rd`=1, `req_cmd_only`=0) gives 32 rising edges. `mosi` carries `req_cmd` for the first 8 bits and 0 for the last 24. `rdata` then holds the last 24 bits sampled on `miso`, with the first of them in bit 23.
- R5: A command-only frame (`req_cmd_only`=1, whatever `req_rd` is) gives exactly 8 rising edges that carry `req_cmd` MSB first, and leaves `rdata` unchanged.
- R6: A write leaves `rdata` unchanged.
- R7: Serial mode 0 is used. `mosi` changes only while `sclk` is 0. `miso` is sampled on the system clock edge that raises `sclk`.
- R8: Each `sclk` high phase and each low phase lasts exactly HALF = ceil(SYS_CLK_HZ / (2*SCLK_MAX_HZ)) system clocks, so the serial rate never exceeds SCLK_MAX_HZ.
- R9: At least HALF clocks separate the start of the frame (chip select falling) from the first rising `sclk` edge. At least HALF clocks separate the last falling edge from the end of the frame. Chip select stays active for the whole frame.
- R10: `done` is high for exactly one clock per transaction, in the same cycle in which `busy` returns to 0.
- R11: With CS_TIED=1, `cs_n` stays 0 at all times. All other outputs behave exactly as in the per-transaction mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe for one transaction |
| req_cmd | input | CMD_W | Command byte |
| req_rd | input | 1 | 1 selects a read payload, 0 a write payload |
| req_cmd_only | input | 1 | 1 sends only the command byte |
| req_wdata | input | DATA_W | Word shifted out on a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Word received by the last read |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |

## Verification
A walking one is sent through every payload bit position, first as write data and then as converter reply data. This catches a reversed bit order, a byte swap or an off-by-one in the position where the payload starts. Scrambled arithmetic words, including all-zero and all-ones, are mixed with these reads, writes and command-only frames in varying order. That mix shows whether `rdata` is held across writes and command-only frames, and whether the read path really drives zeros. A start strobe issued in the middle of a frame confirms that the frame and the completion count are untouched. Every frame is also timed edge by edge against HALF for clock phases, chip-select setup and hold. A second instance with chip select tied low is compared with the first throughout the run.

// File: rtl/adc_reg_xact_pkg.sv
package adc_reg_xact_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_HOLD  = 3'd4
  } xact_state_t;

  // System clocks per half serial period, rounded up, never below one.
  function automatic int half_period_clocks(input int sys_hz, input int max_hz);
    int raw;
    raw = (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
    return (raw < 1) ? 1 : raw;
  endfunction

endpackage

// File: rtl/adc_reg_xact_clkdiv.sv
module adc_reg_xact_clkdiv #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_reg_xact_shifter.sv
module adc_reg_xact_shifter #(
  parameter int FRAME_W = 32,
  parameter int RX_W    = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               shift,
  input  logic               sample,
  input  logic               miso,
  output logic               tx_msb,
  output logic [RX_W-1:0]    rx_word
);
  logic [FRAME_W-1:0] tx_q;
  logic [RX_W-1:0]    rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (load)  tx_q <= load_word;
    else if (shift) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_q <= '0;
    else if (sample) rx_q <= {rx_q[RX_W-2:0], miso};
  end

  assign tx_msb  = tx_q[FRAME_W-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/adc_reg_xact.sv
module adc_reg_xact
  import adc_reg_xact_pkg::*;
#(
  parameter int SYS_CLK_HZ  = 200_000_000,
  parameter int SCLK_MAX_HZ = 2_000_000,
  parameter int CMD_W       = 8,
  parameter int DATA_W      = 24,
  parameter bit CS_TIED     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic              req_rd,
  input  logic              req_cmd_only,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int HALF_CYC = half_period_clocks(SYS_CLK_HZ, SCLK_MAX_HZ);
  localparam int FRAME_W  = CMD_W + DATA_W;
  localparam int BCNT_W   = $clog2(FRAME_W);
  localparam logic [BCNT_W-1:0] LAST_FULL = BCNT_W'(FRAME_W - 1);
  localparam logic [BCNT_W-1:0] LAST_CMD  = BCNT_W'(CMD_W - 1);

  xact_state_t       state_q, state_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic              sclk_q, sclk_d;
  logic              done_q, done_d;
  logic              rd_q, only_q;
  logic [DATA_W-1:0] rdata_q;
  logic              accept, load, shift, sample, capture, tick;
  logic              tx_msb;
  logic [DATA_W-1:0] rx_word;
  logic [BCNT_W-1:0] last_bit;

  assign busy     = (state_q != ST_IDLE);
  assign accept   = req_start && !busy;
  assign last_bit = only_q ? LAST_CMD : LAST_FULL;

  adc_reg_xact_clkdiv #(.HALF_CYC(HALF_CYC)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  adc_reg_xact_shifter #(.FRAME_W(FRAME_W), .RX_W(DATA_W)) u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_word({req_cmd, (req_rd ? {DATA_W{1'b0}} : req_wdata)}),
    .shift    (shift),
    .sample   (sample),
    .miso     (miso),
    .tx_msb   (tx_msb),
    .rx_word  (rx_word)
  );

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    sclk_d  = sclk_q;
    done_d  = 1'b0;
    load    = 1'b0;
    shift   = 1'b0;
    sample  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_start) begin
          load    = 1'b1;
          bcnt_d  = '0;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP, ST_LOW: begin
        if (tick) begin
          sclk_d  = 1'b1;
          sample  = 1'b1;
          state_d = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tick) begin
          sclk_d = 1'b0;
          if (bcnt_q == last_bit) begin
            state_d = ST_HOLD;
          end else begin
            shift   = 1'b1;
            bcnt_d  = bcnt_q + 1'b1;
            state_d = ST_LOW;
          end
        end
      end
      ST_HOLD: begin
        if (tick) begin
          done_d  = 1'b1;
          capture = rd_q && !only_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      sclk_q  <= sclk_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      only_q <= 1'b0;
    end else if (accept) begin
      rd_q   <= req_rd;
      only_q <= req_cmd_only;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= rx_word;
  end

  generate
    if (CS_TIED) begin : g_cs_tied
      assign cs_n = 1'b0;
    end else begin : g_cs_frame
      assign cs_n = !busy;
    end
  endgenerate

  assign sclk  = sclk_q;
  assign mosi  = busy ? tx_msb : 1'b0;
  assign done  = done_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/adc_reg_xact_chk.sv
module adc_reg_xact_chk #(
  parameter bit CS_TIED = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic req_start,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk,
  input logic mosi
);
  p_idle_sclk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !mosi));

  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !busy) |=> busy);

  p_mosi_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sclk);

  p_cs_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  p_cs_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !CS_TIED) |-> cs_n);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_cs_tied_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (CS_TIED && $rose(sclk)) |-> !cs_n);
endmodule

bind adc_reg_xact adc_reg_xact_chk #(.CS_TIED(CS_TIED)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_start(req_start),
  .busy     (busy),
  .done     (done),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .mosi     (mosi)
);

// File: tb/adc_reg_xact_bench.sv
module adc_reg_xact_bench;
  localparam int SYS_HZ = 200_000_000;
  localparam int MAX_HZ = 25_000_000;
  localparam int HALF   = (SYS_HZ + 2 * MAX_HZ - 1) / (2 * MAX_HZ);

  logic        clk, rst_n;
  logic        req_start, req_rd, req_cmd_only;
  logic [7:0]  req_cmd;
  logic [23:0] req_wdata;
  logic        busy, done, cs_n, sclk, mosi, miso;
  logic [23:0] rdata;
  logic        t_busy, t_done, t_cs_n, t_sclk, t_mosi;
  logic [23:0] t_rdata;

  int checks = 0;
  int fails  = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  adc_reg_xact #(.SYS_CLK_HZ(SYS_HZ), .SCLK_MAX_HZ(MAX_HZ)) u_adc_reg_xact (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
    .req_rd(req_rd), .req_cmd_only(req_cmd_only), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso));

  adc_reg_xact #(.SYS_CLK_HZ(SYS_HZ), .SCLK_MAX_HZ(MAX_HZ), .CS_TIED(1'b1)) u_adc_reg_xact_tied (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
    .req_rd(req_rd), .req_cmd_only(req_cmd_only), .req_wdata(req_wdata),
    .busy(t_busy), .done(t_done), .rdata(t_rdata), .cs_n(t_cs_n), .sclk(t_sclk),
    .mosi(t_mosi), .miso(miso));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Edge monitor and converter model, evaluated between clock edges.
  int          cyc = 0;
  logic        sclk_p = 1'b0, cs_p = 1'b1, mosi_p = 1'b0;
  logic [31:0] slave_word = '0;
  logic [31:0] cap;
  int          nrise, idx, cs_fall_c, cs_rise_c, first_rise_c, last_rise_c, last_fall_c;
  int          per_bad, mosi_bad, done_cnt, mirror_bad, tied_cs_bad;

  always @(negedge clk) begin
    cyc++;
    if (!cs_n && cs_p) begin
      cs_fall_c = cyc; idx = 0; nrise = 0; cap = '0;
      miso      = slave_word[31];
    end
    if (sclk && !sclk_p) begin
      cap = {cap[30:0], mosi};
      if (nrise == 0) first_rise_c = cyc;
      else if (cyc - last_rise_c != 2 * HALF) per_bad++;
      if (nrise != 0 && cyc - last_fall_c != HALF) per_bad++;
      last_rise_c = cyc;
      nrise++;
    end
    if (!sclk && sclk_p) begin
      if (cyc - last_rise_c != HALF) per_bad++;
      last_fall_c = cyc;
      idx++;
      if (idx < 32) miso = slave_word[31 - idx];
    end
    if (cs_n && !cs_p) cs_rise_c = cyc;
    if (sclk && sclk_p && mosi != mosi_p) mosi_bad++;
    if (done) done_cnt++;
    if (t_cs_n) tied_cs_bad++;
    if (t_sclk != sclk || t_mosi != mosi || t_busy != busy || t_done != done) mirror_bad++;
    sclk_p = sclk; cs_p = cs_n; mosi_p = mosi;
  end

  logic [23:0] exp_rdata = '0;

  task automatic run(input logic [7:0] cmd, input bit rd, input bit only,
                     input logic [23:0] wd, input logic [23:0] pat, input bit poke);
    logic [31:0] exp_frame;
    int          exp_bits;
    slave_word = {8'h00, pat};
    per_bad = 0; mosi_bad = 0; done_cnt = 0;
    @(negedge clk);
    req_cmd = cmd; req_rd = rd; req_cmd_only = only; req_wdata = wd; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
    if (poke) begin
      repeat (5 * HALF) @(negedge clk);
      req_cmd = ~cmd; req_wdata = ~wd; req_rd = ~rd; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R10 busy low with done", 32'(busy), 32'd0);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R10 done pulse count", 32'(done_cnt), 32'd1);
    chk(busy == 1'b0 && cs_n && !sclk && !mosi, "R1 idle lines",
        {28'd0, busy, cs_n, sclk, mosi}, 32'b0100);
    if (poke) chk(busy == 1'b0, "R2 start while busy not queued", 32'(busy), 32'd0);
    exp_bits = only ? 8 : 32;
    exp_frame = only ? {24'd0, cmd} : {cmd, (rd ? 24'd0 : wd)};
    if (only) begin
      chk(nrise == 8, "R5 clock count", 32'(nrise), 32'd8);
      chk(cap[7:0] == cmd, "R5 command bits", {24'd0, cap[7:0]}, {24'd0, cmd});
    end else if (rd) begin
      chk(nrise == exp_bits, "R4 clock count", 32'(nrise), 32'(exp_bits));
      chk(cap == exp_frame, "R4 mosi frame", cap, exp_frame);
    end else begin
      chk(nrise == exp_bits, "R3 clock count", 32'(nrise), 32'(exp_bits));
      chk(cap == exp_frame, "R3 mosi frame", cap, exp_frame);
    end
    if (rd && !only) begin
      exp_rdata = pat;
      chk(rdata == exp_rdata, "R4 read word", {8'd0, rdata}, {8'd0, exp_rdata});
    end else if (only) begin
      chk(rdata == exp_rdata, "R5 rdata held", {8'd0, rdata}, {8'd0, exp_rdata});
    end else begin
      chk(rdata == exp_rdata, "R6 rdata held", {8'd0, rdata}, {8'd0, exp_rdata});
    end
    chk(per_bad == 0, "R8 phase widths", 32'(per_bad), 32'd0);
    chk(mosi_bad == 0, "R7 mosi stable while sclk high", 32'(mosi_bad), 32'd0);
    chk(first_rise_c - cs_fall_c >= HALF, "R9 cs setup", 32'(first_rise_c - cs_fall_c), 32'(HALF));
    chk(cs_rise_c - last_fall_c >= HALF, "R9 cs hold", 32'(cs_rise_c - last_fall_c), 32'(HALF));
    chk(t_rdata == rdata && mirror_bad == 0, "R11 tied instance matches",
        {8'd0, t_rdata} ^ 32'(mirror_bad), {8'd0, rdata});
    chk(tied_cs_bad == 0, "R11 tied cs low", 32'(tied_cs_bad), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    mirror_bad = 0; tied_cs_bad = 0; miso = 1'b0;
    rst_n = 1'b0; req_start = 1'b0; req_cmd = '0; req_rd = 1'b0;
    req_cmd_only = 1'b0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0 && busy == 1'b0 && done == 1'b0,
        "R1 reset state", {27'd0, cs_n, sclk, mosi, busy, done}, 32'b10000);
    chk(t_cs_n == 1'b0, "R11 tied cs after reset", 32'(t_cs_n), 32'd0);
    chk(rdata == 24'd0, "R1 rdata after reset", {8'd0, rdata}, 32'd0);

    for (int i = 0; i < 24; i++)  // walking one through the write payload
      run(8'h80 | 8'(i), 1'b0, 1'b0, 24'd1 << i, 24'hFFFFFF, 1'b0);
    for (int i = 0; i < 24; i++)  // walking one through the read payload
      run(8'h90 | 8'(i), 1'b1, 1'b0, 24'hFFFFFF, 24'd1 << i, 1'b0);
    for (int i = 0; i < 12; i++) begin
      logic [23:0] a;
      a = 24'(i * 32'h5A3C71 + 32'h13579B);
      case (i % 4)
        0: run(8'(i * 37), 1'b1, 1'b0, a, ~a, 1'b0);
        1: run(8'(i * 37), 1'b0, 1'b0, a, a ^ 24'h0F0F0F, 1'b0);
        2: run(8'(i * 37), 1'b0, 1'b1, a, ~a, 1'b0);
        default: run(8'(i * 37), 1'b1, 1'b1, a, a, 1'b0);
      endcase
    end
    run(8'hFF, 1'b1, 1'b0, 24'd0, 24'hFFFFFF, 1'b0);
    run(8'h00, 1'b1, 1'b0, 24'd0, 24'h000000, 1'b0);
    run(8'hC0, 1'b0, 1'b1, 24'hABCDEF, 24'h123456, 1'b0);
    run(8'h82, 1'b0, 1'b0, 24'h800000, 24'h55AA55, 1'b1);
    run(8'h96, 1'b1, 1'b0, 24'h000000, 24'hC3A5E1, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule